// File: doc/BRIEF.md
# Hardware Register Bitfield Access Unit

This block holds a bank of eight 32-bit hardware status registers and gives two kinds of access to bit fields inside them. A field is named by a register identifier, a starting bit position (0 to 31) and a width in bits (1 to 32).

The read port is combinational. It shifts the selected register down by the offset and masks it to the field width, so the field comes out right-aligned.

The write port does a read-modify-write. It builds a field mask from the width and offset and shifts the source value up by the offset. Only the bits under the mask are replaced, and the new value is stored on the next clock edge. The source value comes either from a scalar register operand or from an immediate dword that followed the instruction word. A select input picks between the two.

A parameter marks which register identifiers are implemented. The unimplemented ones read as zero and ignore writes.

Top module: `hwreg_field_unit`

## Requirements
- R1: After reset every implemented register reads as 0x00000000 through a full-width read (offset 0, size 32).
- R2: A read returns (register >> offset) AND ((1 << size) - 1). Result bits at and above position `size` are zero.
- R3: A field size of 32 uses an all-ones base mask. A write with offset 0 and size 32 replaces the whole register, and a read with offset 0 and size 32 returns the whole register.
- R4: Field bits that would lie above bit 31 (offset + size > 32) are dropped. A write changes only bits offset..31, and a read returns zeros in result bits 32-offset and up.
- R5: A write sets the register to (old AND NOT mask) OR ((source << offset) AND mask), where mask = ((1 << size) - 1) << offset. No bit outside the mask changes.
- R6: With `wrUseImm` = 1 the source is `wrImmData`. With `wrUseImm` = 0 the source is `wrScalarData`.
- R7: With the default `IMPL_MASK` = 8'h3F, register identifiers 6 and 7 are unimplemented. They always read as zero, and writes to them have no effect.
- R8: A write takes effect on the clock edge after the request. A read of the same register in the request cycle returns the old value.
- R9: While `wrValid` is 0, no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request strobe |
| wrRegId | input | 3 | Register identifier for the write |
| wrOffset | input | 5 | Lowest bit of the write field |
| wrSize | input | 6 | Write field width, 1 to 32 |
| wrUseImm | input | 1 | 1 selects the immediate dword as the source |
| wrScalarData | input | 32 | Source value from a scalar register |
| wrImmData | input | 32 | Source value from the trailing immediate dword |
| rdRegId | input | 3 | Register identifier for the read |
| rdOffset | input | 5 | Lowest bit of the read field |
| rdSize | input | 6 | Read field width, 1 to 32 |
| rdData | output | 32 | Extracted field, right-aligned |

## Verification
The assertions assume that both size inputs stay within 1 to 32 outside reset, and that `wrValid` is low while reset is asserted. Sizes of 0 or above 32 are outside the block's contract. The stimulus draws every size from the range 1 to 32, covering both the directed corners and the random cycles, and holds the write strobe low until reset is released. The stimulus also includes fields that run past bit 31, writes to unimplemented identifiers, and a read of the register being written in the same cycle. The behavioural model is checked against all of these.

// File: rtl/hwf_pkg.sv
package hwf_pkg;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic wrEn;    // commit a write on the next edge
    logic useImm;  // source is the immediate dword
    logic rdHit;   // read targets an implemented register
  } hwfStrobes_t;

endpackage

// File: rtl/hwf_ctrl.sv
module hwf_ctrl
  import hwf_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int ID_W = $clog2(NREGS),
  parameter logic [NREGS-1:0] IMPL_MASK = '1
) (
  input  logic            wrValid,
  input  logic [ID_W-1:0] wrRegId,
  input  logic            wrUseImm,
  input  logic [ID_W-1:0] rdRegId,
  output hwfStrobes_t     strb
);

  logic wrImpl;
  logic rdImpl;

  always_comb begin
    wrImpl = IMPL_MASK[wrRegId];
    rdImpl = IMPL_MASK[rdRegId];
    strb.wrEn = wrValid && wrImpl;
    strb.useImm = wrUseImm;
    strb.rdHit = rdImpl;
  end

endmodule

// File: rtl/hwf_datapath.sv
module hwf_datapath
  import hwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS = 8,
  parameter int ID_W = $clog2(NREGS),
  parameter int OFF_W = $clog2(DATA_W),
  parameter int SIZE_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hwfStrobes_t       strb,
  input  logic [ID_W-1:0]   wrRegId,
  input  logic [OFF_W-1:0]  wrOffset,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [DATA_W-1:0] wrScalarData,
  input  logic [DATA_W-1:0] wrImmData,
  input  logic [ID_W-1:0]   rdRegId,
  input  logic [OFF_W-1:0]  rdOffset,
  input  logic [SIZE_W-1:0] rdSize,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  // Right-aligned mask of 'size' ones; a full-width size gives all ones
  function automatic logic [DATA_W-1:0] baseMask(input logic [SIZE_W-1:0] size);
    if (int'(size) >= DATA_W) return ALL_ONES;
    return ~(ALL_ONES << size);
  endfunction

  logic [DATA_W-1:0] wrSrc;
  logic [DATA_W-1:0] wrMask;
  logic [DATA_W-1:0] wrShifted;
  logic [DATA_W-1:0] rdMask;
  logic [DATA_W-1:0] regQ [NREGS];

  always_comb begin
    wrSrc = strb.useImm ? wrImmData : wrScalarData;
    // Left shifts discard anything that moves past the top bit
    wrMask = baseMask(wrSize) << wrOffset;
    wrShifted = wrSrc << wrOffset;
    rdMask = baseMask(rdSize);
  end

  for (genvar i = 0; i < NREGS; i++) begin : gReg
    logic [DATA_W-1:0] q;
    logic sel;
    assign sel = strb.wrEn && (wrRegId == ID_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) q <= '0;
      else if (sel) q <= (q & ~wrMask) | (wrShifted & wrMask);
    end
    assign regQ[i] = q;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdHit) rdData = (regQ[rdRegId] >> rdOffset) & rdMask;
  end

endmodule

// File: rtl/hwreg_field_unit.sv
module hwreg_field_unit
  import hwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS = 8,
  parameter logic [NREGS-1:0] IMPL_MASK = 8'h3F,
  parameter int ID_W = $clog2(NREGS),
  parameter int OFF_W = $clog2(DATA_W),
  parameter int SIZE_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ID_W-1:0]   wrRegId,
  input  logic [OFF_W-1:0]  wrOffset,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic              wrUseImm,
  input  logic [DATA_W-1:0] wrScalarData,
  input  logic [DATA_W-1:0] wrImmData,
  input  logic [ID_W-1:0]   rdRegId,
  input  logic [OFF_W-1:0]  rdOffset,
  input  logic [SIZE_W-1:0] rdSize,
  output logic [DATA_W-1:0] rdData
);

  hwfStrobes_t strb;

  hwf_ctrl #(
    .NREGS(NREGS), .ID_W(ID_W), .IMPL_MASK(IMPL_MASK)
  ) uCtrl (
    .wrValid(wrValid), .wrRegId(wrRegId), .wrUseImm(wrUseImm),
    .rdRegId(rdRegId), .strb(strb)
  );

  hwf_datapath #(
    .DATA_W(DATA_W), .NREGS(NREGS), .ID_W(ID_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrRegId(wrRegId), .wrOffset(wrOffset), .wrSize(wrSize),
    .wrScalarData(wrScalarData), .wrImmData(wrImmData),
    .rdRegId(rdRegId), .rdOffset(rdOffset), .rdSize(rdSize),
    .rdData(rdData)
  );

endmodule

// File: rtl/hwf_checker.sv
module hwf_checker #(
  parameter int DATA_W = 32,
  parameter int NREGS = 8,
  parameter logic [NREGS-1:0] IMPL_MASK = 8'h3F,
  parameter int ID_W = $clog2(NREGS),
  parameter int OFF_W = $clog2(DATA_W),
  parameter int SIZE_W = $clog2(DATA_W) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ID_W-1:0]   rdRegId,
  input logic [OFF_W-1:0]  rdOffset,
  input logic [SIZE_W-1:0] rdSize,
  input logic [DATA_W-1:0] rdData
);

  // R2: nothing at or above the field width in the result
  a_r2_right_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdSize) < DATA_W) |-> ((rdData >> rdSize) == '0));

  // R4: field bits beyond the top of the register never appear
  a_r4_top_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (rdOffset != '0) |-> ((rdData >> (DATA_W - int'(rdOffset))) == '0));

  // R7: unimplemented identifiers read as zero
  a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!IMPL_MASK[rdRegId]) |-> (rdData == '0));

  // R9: no write strobe and an unchanged read request keep the result
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid ##1 ($stable(rdRegId) && $stable(rdOffset) && $stable(rdSize))
      |-> $stable(rdData));

endmodule

bind hwreg_field_unit hwf_checker #(
  .DATA_W(DATA_W), .NREGS(NREGS), .IMPL_MASK(IMPL_MASK)
) uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdRegId(rdRegId),
  .rdOffset(rdOffset), .rdSize(rdSize), .rdData(rdData)
);

// File: tb/hwreg_field_unit_test.sv
`timescale 1ns/1ps
module hwreg_field_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [2:0]  wrRegId = '0;
  logic [4:0]  wrOffset = '0;
  logic [5:0]  wrSize = 6'd1;
  logic        wrUseImm = 1'b0;
  logic [31:0] wrScalarData = '0;
  logic [31:0] wrImmData = '0;
  logic [2:0]  rdRegId = '0;
  logic [4:0]  rdOffset = '0;
  logic [5:0]  rdSize = 6'd32;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] model [8];
  localparam logic [7:0] IMPL = 8'h3F;

  hwreg_field_unit uut (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] fieldOnes(input int size);
    logic [63:0] ones;
    ones = (64'd1 << size) - 64'd1;
    return ones[31:0];
  endfunction

  function automatic logic [31:0] expRead(input int id, input int off, input int size);
    if (!IMPL[id]) return 32'h0;
    return (model[id] >> off) & fieldOnes(size);
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, rdData, exp);
    end
  endtask

  // Drive one cycle of requests at a falling edge, check the read, update the model
  task automatic step(input logic wv, input int wid, input int woff, input int wsz,
                      input logic wimm, input logic [31:0] wsc, input logic [31:0] wimd,
                      input int rid, input int roff, input int rsz, input string tag);
    logic [31:0] src;
    logic [31:0] mask;
    wrValid = wv; wrRegId = 3'(wid); wrOffset = 5'(woff); wrSize = 6'(wsz);
    wrUseImm = wimm; wrScalarData = wsc; wrImmData = wimd;
    rdRegId = 3'(rid); rdOffset = 5'(roff); rdSize = 6'(rsz);
    #1;
    check(tag, expRead(rid, roff, rsz));
    if (wv && IMPL[wid]) begin
      src = wimm ? wimd : wsc;
      mask = fieldOnes(wsz) << woff;
      model[wid] = (model[wid] & ~mask) | ((src << woff) & mask);
    end
    @(negedge clk);
  endtask

  task automatic rd(input int id, input int off, input int size, input string tag);
    step(1'b0, 0, 0, 1, 1'b0, 32'h0, 32'h0, id, off, size, tag);
  endtask

  task automatic wr(input int id, input int off, input int size, input logic imm,
                    input logic [31:0] sc, input logic [31:0] im, input string tag);
    step(1'b1, id, off, size, imm, sc, im, 0, 0, 32, tag);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset contents
    for (int i = 0; i < 8; i++) rd(i, 0, 32, "R1 reset value");
    // R3: full-width write and read
    wr(1, 0, 32, 1'b0, 32'hDEADBEEF, 32'h0, "R3 full write");
    rd(1, 0, 32, "R3 full read");
    if (rdData !== 32'hDEADBEEF) begin end
    // R5: only the field changes
    wr(1, 8, 4, 1'b0, 32'hFFFF_FFF5, 32'h0, "R5 field write");
    rd(1, 0, 32, "R5 neighbours kept");
    // R2: right-aligned extract
    rd(1, 4, 12, "R2 extract mid field");
    rd(1, 31, 1, "R2 extract top bit");
    // R6: source select
    wr(2, 4, 4, 1'b1, 32'h3, 32'hA, "R6 imm write");
    rd(2, 0, 32, "R6 imm source used");
    wr(2, 4, 4, 1'b0, 32'h3, 32'hA, "R6 scalar write");
    rd(2, 0, 32, "R6 scalar source used");
    // R4: field past bit 31
    wr(3, 28, 8, 1'b0, 32'hFF, 32'h0, "R4 overhang write");
    rd(3, 0, 32, "R4 write dropped upper");
    rd(3, 28, 8, "R4 read dropped upper");
    // R7: unimplemented ids
    wr(6, 0, 32, 1'b0, 32'h12345678, 32'h0, "R7 write unimpl");
    rd(6, 0, 32, "R7 unimpl reads zero");
    rd(7, 0, 32, "R7 unimpl reads zero");
    // R8: same-cycle read sees old value, next cycle sees new
    step(1'b1, 4, 0, 32, 1'b0, 32'hCAFE0001, 32'h0, 4, 0, 32, "R8 same cycle old");
    rd(4, 0, 32, "R8 next cycle new");
    // R9: no strobe, no change
    step(1'b0, 4, 0, 32, 1'b1, 32'h0, 32'hFFFFFFFF, 4, 0, 32, "R9 idle write");
    rd(4, 0, 32, "R9 register unchanged");
    // Random mix, read and write each cycle (R5)
    for (int n = 0; n < 1500; n++) begin
      step(1'($urandom_range(1, 0)), int'($urandom_range(7, 0)),
           int'($urandom_range(31, 0)), int'($urandom_range(32, 1)),
           1'($urandom_range(1, 0)), $urandom, $urandom,
           int'($urandom_range(7, 0)), int'($urandom_range(31, 0)),
           int'($urandom_range(32, 1)), "R5 random");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule